// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Aggregator

This block collects the interrupt sources of an Ethernet MAC into a single nine-bit status register. A simple register port reads and writes it. Each source has one of three update rules:

- **Edge-captured.** The PHY interrupt pin is synchronised, and its rising edge sets a bit.
- **Level-mirrored.** The counter-module summary bits follow their input vectors every cycle.
- **Sticky.** Wake, low-power, timestamp, transmit-status and receive-status events set a bit that stays set until software clears it.

A control bit chooses how sticky bits are cleared, and software may change it at run time. When the bit is 0, reading the status register clears them. When it is 1, writing a 1 to a bit clears that bit.

A per-source enable register masks the status bits. The masked bits are OR-reduced into one registered interrupt request. The status and enable registers are also driven out as ports so that neighbouring logic can observe them.

Top module: `eth_irq_aggregator`

## Requirements
- R1: After reset, `status_o`, `enable_o`, the clear-mode control bit, `irq_o` and `reg_rdata` are all zero.
- R2: Status bit 0 (PHY) is set by a low-to-high change of `phy_irq_pin`, after a two-flop synchroniser. The bit is first seen high after the third rising clock edge that follows the change. A pin that stays high does not set the bit again once it has been cleared.
- R3: A one-cycle pulse on `wake_evt` sets status bit 1. A one-cycle pulse on `lowpwr_evt` sets status bit 2. The change is seen after the next clock edge.
- R4: Status bit 5 is the OR of `cnt_tx_vec`. Bit 4 is the OR of `cnt_rx_vec`. Bit 3 is the OR of bits 4 and 5. Each is registered one cycle, and bit 3 drops only when both vectors are zero. Reads and writes never clear these bits.
- R5: Status bit 6 is set when any of the four `ts_evt` lines is high:
  - target time reached or passed;
  - seconds overflow;
  - target already elapsed;
  - auxiliary snapshot.
- R6: Status bit 7 is set when any of the six `tx_err` flags is high:
  - excessive collision;
  - late collision;
  - excessive deferral;
  - carrier loss;
  - no carrier;
  - jabber timeout.
  Status bit 8 is set when `rx_wdt` is high.
- R7: With control bit 0 at 0, a read of address 0 returns the status before the clear. The sticky bits (0, 1, 2, 6, 7, 8) are zero after that same edge. Writes to address 0 have no effect in this mode.
- R8: With control bit 0 at 1, a write to address 0 clears exactly the sticky bits written as 1. Reads of address 0 clear nothing.
- R9: When a set event and a clear on the same bit fall in the same cycle, the bit ends up set.
- R10: Address 1 holds the enable register, bits [8:0]. `irq_o` equals the OR of (status AND enable), registered one cycle after the status.
- R11: `reg_rdata` is loaded one cycle after `reg_rd`, as follows, and holds its value while `reg_rd` is low:
  - address 0 returns the status;
  - address 1 returns the enables;
  - address 2 returns the control bit in bit 0;
  - address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_irq_pin | input | 1 | Asynchronous PHY interrupt pin |
| wake_evt | input | 1 | Wake packet received pulse |
| lowpwr_evt | input | 1 | Low-power state entry/exit pulse |
| cnt_tx_vec | input | CNT_W | Transmit counter interrupt vector |
| cnt_rx_vec | input | CNT_W | Receive counter interrupt vector |
| ts_evt | input | 4 | Timestamp event lines |
| tx_err | input | 6 | Transmit error flags |
| rx_wdt | input | 1 | Receive watchdog timeout flag |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Registered read data |
| status_o | output | 9 | Status register |
| enable_o | output | 9 | Enable register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the event inputs are synchronous to `clk` and that a read and a write never share a cycle. Only `phy_irq_pin` may change without regard to the clock. The bench changes every input on the falling edge and never raises both strobes together. The bench deliberately drives events in the same cycle as clearing reads and writes, which exercises the set-wins rule.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
  localparam int NUM_SRC   = 9;
  localparam int NUM_TS    = 4;
  localparam int NUM_TXERR = 6;
  localparam int ADDR_W    = 2;

  localparam int B_PHY    = 0;
  localparam int B_WAKE   = 1;
  localparam int B_LPWR   = 2;
  localparam int B_CNT    = 3;
  localparam int B_CNT_RX = 4;
  localparam int B_CNT_TX = 5;
  localparam int B_TS     = 6;
  localparam int B_TXS    = 7;
  localparam int B_RXS    = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_ENABLE = 2'd1,
    REG_CTRL   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  function automatic logic [NUM_SRC-1:0] build_sticky_mask();
    logic [NUM_SRC-1:0] m;
    m = '1;
    m[B_CNT]    = 1'b0;
    m[B_CNT_RX] = 1'b0;
    m[B_CNT_TX] = 1'b0;
    return m;
  endfunction

  localparam logic [NUM_SRC-1:0] STICKY_MASK = build_sticky_mask();

  function automatic logic irq_request(logic [NUM_SRC-1:0] st,
                                       logic [NUM_SRC-1:0] en);
    return |(st & en);
  endfunction

  function automatic logic [NUM_SRC-1:0] gather_events(
      logic phy_rise, logic wake, logic lpwr, logic rx_any, logic tx_any,
      logic ts_any, logic txs_any, logic rxs);
    logic [NUM_SRC-1:0] v;
    v           = '0;
    v[B_PHY]    = phy_rise;
    v[B_WAKE]   = wake;
    v[B_LPWR]   = lpwr;
    v[B_CNT]    = rx_any | tx_any;
    v[B_CNT_RX] = rx_any;
    v[B_CNT_TX] = tx_any;
    v[B_TS]     = ts_any;
    v[B_TXS]    = txs_any;
    v[B_RXS]    = rxs;
    return v;
  endfunction
endpackage

// File: rtl/eth_irq_edge_sync.sv
module eth_irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its delay
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R2: an edge is reported for one cycle only
  assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/eth_irq_status_bank.sv
module eth_irq_status_bank
  import eth_irq_pkg::*;
#(
  parameter int                 N    = NUM_SRC,
  parameter logic [N-1:0]       MASK = STICKY_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic         rd_clr_i,
  input  logic [N-1:0] wr_clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (MASK[i]) begin : g_sticky
      logic clr_w;
      assign clr_w = rd_clr_i | wr_clr_i[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o[i] <= 1'b0;
        else        q_o[i] <= ev_i[i] | (q_o[i] & ~clr_w);
      end

      assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i[i] |=> q_o[i]);
      assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !ev_i[i]) |=> !q_o[i]);
      assert_write_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr_i[i] && !ev_i[i]) |=> !q_o[i]);
      assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_i[i] && !rd_clr_i && !wr_clr_i[i]) |=> $stable(q_o[i]));
    end else begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o[i] <= 1'b0;
        else        q_o[i] <= ev_i[i];
      end

      assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q_o[i] == $past(ev_i[i])));
    end
  end
endmodule

// File: rtl/eth_irq_aggregator.sv
module eth_irq_aggregator
  import eth_irq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 phy_irq_pin,
  input  logic                 wake_evt,
  input  logic                 lowpwr_evt,
  input  logic [CNT_W-1:0]     cnt_tx_vec,
  input  logic [CNT_W-1:0]     cnt_rx_vec,
  input  logic [NUM_TS-1:0]    ts_evt,
  input  logic [NUM_TXERR-1:0] tx_err,
  input  logic                 rx_wdt,
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [NUM_SRC-1:0]   reg_wdata,
  output logic [NUM_SRC-1:0]   reg_rdata,
  output logic [NUM_SRC-1:0]   status_o,
  output logic [NUM_SRC-1:0]   enable_o,
  output logic                 irq_o
);
  logic               phy_rise;
  logic               rd_status, wr_status, rd_clr;
  logic [NUM_SRC-1:0] wr_clr, ev_vec, status_q, enable_q, rdata_next;
  logic               rcwe_q;

  eth_irq_edge_sync #(.STAGES(SYNC_STAGES)) u_phy_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (phy_irq_pin),
    .rise_o  (phy_rise)
  );

  assign rd_status = reg_rd && (reg_addr == REG_STATUS);
  assign wr_status = reg_wr && (reg_addr == REG_STATUS);
  assign rd_clr    = rd_status && !rcwe_q;
  assign wr_clr    = (wr_status && rcwe_q) ? (reg_wdata & STICKY_MASK) : '0;

  assign ev_vec = gather_events(phy_rise, wake_evt, lowpwr_evt, |cnt_rx_vec,
                                |cnt_tx_vec, |ts_evt, |tx_err, rx_wdt);

  eth_irq_status_bank #(.N(NUM_SRC), .MASK(STICKY_MASK)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev_vec),
    .rd_clr_i (rd_clr),
    .wr_clr_i (wr_clr),
    .q_o      (status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      rcwe_q   <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == REG_ENABLE) enable_q <= reg_wdata;
      if (reg_addr == REG_CTRL)   rcwe_q   <= reg_wdata[0];
    end
  end

  always_comb begin
    rdata_next = '0;
    case (reg_addr)
      REG_STATUS: rdata_next = status_q;
      REG_ENABLE: rdata_next = enable_q;
      REG_CTRL:   rdata_next[0] = rcwe_q;
      default:    rdata_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rdata_next;
      irq_o <= irq_request(status_q, enable_q);
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;

  assert_phy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rise |=> status_q[B_PHY]);
  assert_cnt_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_q[B_CNT] == (status_q[B_CNT_RX] | status_q[B_CNT_TX])));
  assert_read_preclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |=> (reg_rdata == $past(status_q)));
  assert_read_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && rcwe_q && !reg_wr) |=>
      ((($past(status_q) & STICKY_MASK) & ~status_q) == '0));
  assert_irq_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(status_q & enable_q))));
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/eth_irq_aggregator_test.sv
module eth_irq_aggregator_test;
  import eth_irq_pkg::*;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phy_irq_pin = 0, wake_evt = 0, lowpwr_evt = 0, rx_wdt = 0;
  logic [CW-1:0] cnt_tx_vec = '0, cnt_rx_vec = '0;
  logic [3:0] ts_evt = '0;
  logic [5:0] tx_err = '0;
  logic reg_rd = 0, reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [8:0] reg_wdata = '0;
  logic [8:0] reg_rdata, status_o, enable_o;
  logic irq_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eth_irq_aggregator #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .phy_irq_pin(phy_irq_pin), .wake_evt(wake_evt),
    .lowpwr_evt(lowpwr_evt), .cnt_tx_vec(cnt_tx_vec), .cnt_rx_vec(cnt_rx_vec),
    .ts_evt(ts_evt), .tx_err(tx_err), .rx_wdt(rx_wdt), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .status_o(status_o), .enable_o(enable_o), .irq_o(irq_o)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string bit_tag(int b);
    case (b)
      0:       return "R2";
      1, 2:    return "R3";
      3, 4, 5: return "R4";
      6:       return "R5";
      default: return "R6";
    endcase
  endfunction

  // behavioural reference, updated on each rising edge
  bit [8:0] m_status, m_enable, m_rdata;
  bit m_rcwe, m_irq;
  bit pin_hist[$];
  localparam bit [8:0] STICKY = 9'b111000111;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_status = '0; m_enable = '0; m_rdata = '0; m_rcwe = 0; m_irq = 0;
      pin_hist = {0, 0, 0};
    end else begin
      bit [8:0] setv, clr, nxt;
      bit rise;
      m_irq = (m_status & m_enable) != 0;
      rise = pin_hist[1] && !pin_hist[2];
      pin_hist.push_front(phy_irq_pin);
      void'(pin_hist.pop_back());
      if (reg_rd) begin
        if (reg_addr == 0)      m_rdata = m_status;
        else if (reg_addr == 1) m_rdata = m_enable;
        else if (reg_addr == 2) m_rdata = {8'b0, m_rcwe};
        else                    m_rdata = '0;
      end
      clr = '0;
      if (reg_rd && reg_addr == 0 && !m_rcwe) clr = STICKY;
      if (reg_wr && reg_addr == 0 && m_rcwe)  clr = reg_wdata & STICKY;
      setv = {rx_wdt, tx_err != 0, ts_evt != 0, 3'b000, lowpwr_evt, wake_evt, rise};
      nxt = (setv | (m_status & ~clr)) & STICKY;
      nxt[5] = cnt_tx_vec != 0;
      nxt[4] = cnt_rx_vec != 0;
      nxt[3] = nxt[4] | nxt[5];
      m_status = nxt;
      if (reg_wr && reg_addr == 1) m_enable = reg_wdata;
      if (reg_wr && reg_addr == 2) m_rcwe = reg_wdata[0];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int b = 0; b < 9; b++)
        check(status_o[b] == m_status[b], bit_tag(b), $sformatf("status bit %0d", b),
              int'(status_o[b]), int'(m_status[b]));
      check(irq_o == m_irq, "R10", "irq_o", int'(irq_o), int'(m_irq));
      check(enable_o == m_enable, "R10", "enable_o", int'(enable_o), int'(m_enable));
      check(reg_rdata == m_rdata, "R11", "reg_rdata", int'(reg_rdata), int'(m_rdata));
    end
  end

  task automatic do_read(input logic [1:0] a, output logic [8:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] rd;
    repeat (3) @(negedge clk);
    check(status_o == 0 && enable_o == 0 && irq_o == 0 && reg_rdata == 0, "R1",
          "reset state", int'({status_o, irq_o}), 0);
    rst_n = 1;
    @(negedge clk);
    do_read(2'd2, rd);
    check(rd == 0, "R1", "control after reset", int'(rd), 0);

    // R2 PHY edge latency
    @(negedge clk); phy_irq_pin = 1;
    @(negedge clk); @(negedge clk);
    check(status_o[0] == 0, "R2", "phy before third edge", int'(status_o[0]), 0);
    @(negedge clk);
    check(status_o[0] == 1, "R2", "phy after third edge", int'(status_o[0]), 1);
    do_read(2'd0, rd);
    check(rd[0] == 1, "R7", "read returns pre-clear phy", int'(rd[0]), 1);
    check(status_o[0] == 0, "R7", "phy cleared by read", int'(status_o[0]), 0);
    repeat (4) @(negedge clk);
    check(status_o[0] == 0, "R2", "held pin does not re-set", int'(status_o[0]), 0);
    phy_irq_pin = 0;

    // R3 wake and low-power pulses
    @(negedge clk); wake_evt = 1;
    @(negedge clk); wake_evt = 0;
    check(status_o[1] == 1, "R3", "wake bit", int'(status_o[1]), 1);
    lowpwr_evt = 1;
    @(negedge clk); lowpwr_evt = 0;
    check(status_o[2] == 1, "R3", "low-power bit", int'(status_o[2]), 1);

    // R4 counter summaries
    cnt_tx_vec = 8'h10;
    @(negedge clk);
    check(status_o[5:3] == 3'b101, "R4", "tx summary", int'(status_o[5:3]), 5);
    cnt_rx_vec = 8'h01;
    @(negedge clk);
    do_read(2'd0, rd);
    check(status_o[5:3] == 3'b111, "R4", "summaries survive read", int'(status_o[5:3]), 7);
    cnt_tx_vec = 0;
    @(negedge clk);
    check(status_o[5:3] == 3'b011, "R4", "rx only keeps summary", int'(status_o[5:3]), 3);
    cnt_rx_vec = 0;
    @(negedge clk);
    check(status_o[5:3] == 3'b000, "R4", "summary drops", int'(status_o[5:3]), 0);

    // R5 each timestamp line
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ts_evt = 4'(1 << i);
      @(negedge clk); ts_evt = 0;
      check(status_o[6] == 1, "R5", $sformatf("ts line %0d", i), int'(status_o[6]), 1);
      do_read(2'd0, rd);
    end

    // R6 each transmit error and the watchdog
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); tx_err = 6'(1 << i);
      @(negedge clk); tx_err = 0;
      check(status_o[7] == 1, "R6", $sformatf("tx err %0d", i), int'(status_o[7]), 1);
      do_read(2'd0, rd);
    end
    @(negedge clk); rx_wdt = 1;
    @(negedge clk); rx_wdt = 0;
    check(status_o[8] == 1, "R6", "rx watchdog", int'(status_o[8]), 1);

    // R7 write ignored in clear-on-read mode
    do_write(2'd0, 9'h1FF);
    check(status_o[8] == 1, "R7", "write ignored", int'(status_o[8]), 1);
    do_read(2'd0, rd);

    // R8 write-one-to-clear mode
    do_write(2'd2, 9'h001);
    do_read(2'd2, rd);
    check(rd == 9'h001, "R11", "control readback", int'(rd), 1);
    @(negedge clk); wake_evt = 1; lowpwr_evt = 1;
    @(negedge clk); wake_evt = 0; lowpwr_evt = 0;
    do_read(2'd0, rd);
    check(status_o[2:1] == 2'b11, "R8", "read keeps bits", int'(status_o[2:1]), 3);
    do_write(2'd0, 9'h002);
    check(status_o[2:1] == 2'b10, "R8", "only bit 1 cleared", int'(status_o[2:1]), 2);

    // R9 set beats clear
    @(negedge clk); lowpwr_evt = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 9'h004;
    @(negedge clk); lowpwr_evt = 0; reg_wr = 0;
    check(status_o[2] == 1, "R9", "set wins over write clear", int'(status_o[2]), 1);
    do_write(2'd2, 9'h000);
    @(negedge clk); wake_evt = 1; reg_rd = 1; reg_addr = 0;
    @(negedge clk); wake_evt = 0; reg_rd = 0;
    check(status_o[1] == 1 && status_o[2] == 0, "R9", "set wins over read clear",
          int'(status_o[2:1]), 1);

    // R10 enables and combined output
    do_read(2'd0, rd);
    do_write(2'd1, 9'h040);
    @(negedge clk); wake_evt = 1;
    @(negedge clk); wake_evt = 0;
    @(negedge clk);
    check(irq_o == 0, "R10", "masked source no irq", int'(irq_o), 0);
    ts_evt = 4'b0100;
    @(negedge clk); ts_evt = 0;
    check(irq_o == 0, "R10", "irq one cycle after status", int'(irq_o), 0);
    @(negedge clk);
    check(irq_o == 1, "R10", "irq raised", int'(irq_o), 1);
    do_read(2'd1, rd);
    check(rd == 9'h040, "R11", "enable readback", int'(rd), 'h40);

    // mixed stimulus, compared cycle by cycle against the model
    for (int c = 0; c < 4000; c++) begin
      int r;
      @(negedge clk);
      r = int'($urandom_range(0, 99));
      wake_evt   = ($urandom_range(0, 15) == 0);
      lowpwr_evt = ($urandom_range(0, 15) == 0);
      rx_wdt     = ($urandom_range(0, 31) == 0);
      ts_evt     = ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'b0;
      tx_err     = ($urandom_range(0, 15) == 0) ? 6'($urandom) : 6'b0;
      if ($urandom_range(0, 20) == 0) cnt_tx_vec = ($urandom_range(0, 1) == 1) ? CW'($urandom) : '0;
      if ($urandom_range(0, 20) == 0) cnt_rx_vec = ($urandom_range(0, 1) == 1) ? CW'($urandom) : '0;
      if ($urandom_range(0, 9) == 0) phy_irq_pin = ~phy_irq_pin;
      reg_rd = (r < 20);
      reg_wr = (r >= 20 && r < 35);
      reg_addr = 2'($urandom);
      reg_wdata = 9'($urandom);
    end
    @(negedge clk);
    reg_rd = 0; reg_wr = 0; wake_evt = 0; lowpwr_evt = 0; rx_wdt = 0; ts_evt = 0; tx_err = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule